// File: doc/BRIEF.md
# Serial Command Packet Parser and Validator

This block sits behind a serial byte receiver and turns the incoming byte stream into checked five-byte command packets. Each packet opens with an identifier byte, carries two operand bytes, then an integrity byte, and closes by repeating the identifier. The block counts bytes to keep its place in the frame. When the closing byte arrives it judges the whole packet. A sound packet produces a one-cycle command strobe carrying the identifier and both operands. A faulty packet produces a one-cycle negative-acknowledge request instead, so that reply logic elsewhere can report the error.

The checks depend on the identifier. Every packet must end with a copy of its identifier. Most packets carry the 8-bit sum of the two operands as the integrity byte. The bulk-address command carries a zero byte in that position instead of a sum. The single-byte write command also requires its second operand to be the bitwise inverse of the first. An identifier outside the legal set is rejected as soon as it arrives, and framing restarts at once. A packet left unfinished for a configurable number of idle clock cycles is dropped silently.

Top module: `cmd_pkt_parser`

## Requirements
- R1: After reset, `cmd_valid` and `nak_req` are low, and the first byte accepted is taken as a packet identifier.
- R2: The legal identifiers are 0x02, 0x03, 0x04, 0x05, 0x10, 0x11, 0x20, 0x21, 0x22, 0x23 and 0x80. Suppose a byte accepted in the identifier position is not one of these. Then `nak_req` is high for the single cycle after that byte's clock edge, and the next accepted byte is again taken as an identifier.
- R3: A packet is five accepted bytes in this order: identifier, operand 1, operand 2, integrity byte, trailer. When the packet passes every check, `cmd_valid` is high for exactly the one cycle after the trailer's clock edge. In that cycle `cmd_id`, `cmd_op1` and `cmd_op2` hold bytes 1, 2 and 3 of the packet.
- R4: For every identifier other than 0x80, the integrity byte must equal (operand 1 + operand 2) mod 256. Otherwise the packet raises `nak_req` in place of `cmd_valid`.
- R5: The trailer must equal the identifier. Otherwise the packet raises `nak_req` in place of `cmd_valid`.
- R6: For identifier 0x10, operand 2 must equal the bitwise inverse of operand 1. Otherwise the packet raises `nak_req`.
- R7: For identifier 0x80, the integrity byte must be 0x00 and no sum check applies. Any other value raises `nak_req`.
- R8: `cmd_valid` and `nak_req` are never high in the same cycle.
- R9: When a packet is partly received and `TIMEOUT_CYC` consecutive clock edges pass with `rx_valid` low, the partial packet is discarded without any output. The next accepted byte is taken as an identifier. A gap of `TIMEOUT_CYC`-1 edges leaves the packet intact.
- R10: After a packet ends, whether accepted or rejected, the very next accepted byte starts a new packet, even when it follows with no idle cycle.
- R11: A byte is accepted only on a clock edge where `rx_valid` is high. Values on `rx_byte` while `rx_valid` is low have no effect on framing or outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | A received byte is present on `rx_byte` this cycle |
| rx_byte | input | 8 | Received byte |
| cmd_valid | output | 1 | One-cycle strobe for an accepted command |
| cmd_id | output | 8 | Identifier of the accepted command |
| cmd_op1 | output | 8 | First operand of the accepted command |
| cmd_op2 | output | 8 | Second operand of the accepted command |
| nak_req | output | 1 | One-cycle request to send a negative acknowledge |

## Verification
The bound checker watches several properties on every cycle. It confirms that the command strobe and the negative-acknowledge request never overlap. It confirms that a command strobe lasts one cycle, names a legal identifier, follows a trailer equal to that identifier, and satisfies the inverse rule for single-byte writes. It confirms that framing is at the identifier position whenever either output fires, and that framing has restarted once the idle limit is reached. Some faults cannot be seen from the outputs of a good packet: a wrong integrity sum, a nonzero fourth byte on the bulk-address command, an off-by-one idle limit, and ignored bytes carried over. Only the bench's directed scenarios can show these, by comparing the outcome with a value worked out by hand.

// File: rtl/cmd_pkt_pkg.sv
package cmd_pkt_pkg;

   localparam int BYTE_W   = 8;
   localparam int PKT_LEN  = 5;
   localparam int HDR_FLDS = 4;   // id, op1, op2, integrity; trailer is checked live

   typedef logic [BYTE_W-1:0] byte_t;

   localparam byte_t ID_RD_RAM_B = 8'h02;
   localparam byte_t ID_RD_RAM_W = 8'h03;
   localparam byte_t ID_RD_ROM_B = 8'h04;
   localparam byte_t ID_RD_ROM_W = 8'h05;
   localparam byte_t ID_WR_BYTE  = 8'h10;
   localparam byte_t ID_WR_WORD  = 8'h11;
   localparam byte_t ID_DST_LO   = 8'h20;
   localparam byte_t ID_DST_HI   = 8'h23;
   localparam byte_t ID_BULK_ADR = 8'h80;

   typedef struct packed {
      byte_t id;
      byte_t op1;
      byte_t op2;
      byte_t chk;
   } pkt_hdr_t;

   function automatic logic id_is_legal(input byte_t id);
      logic ok;
      ok = 1'b0;
      if (id >= ID_RD_RAM_B && id <= ID_RD_ROM_W) ok = 1'b1;
      if (id == ID_WR_BYTE || id == ID_WR_WORD)   ok = 1'b1;
      if (id >= ID_DST_LO && id <= ID_DST_HI)     ok = 1'b1;
      if (id == ID_BULK_ADR)                      ok = 1'b1;
      return ok;
   endfunction

   function automatic byte_t op_sum(input byte_t a, input byte_t b);
      return byte_t'(a + b);
   endfunction

endpackage

// File: rtl/cmd_pkt_framer.sv
module cmd_pkt_framer
   import cmd_pkt_pkg::*;
#(
   parameter int TIMEOUT_CYC = 1000,
   parameter int POS_W       = 3
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_valid,
   input  logic             id_ok,
   output logic [POS_W-1:0] pos,
   output logic             id_drop,
   output logic             pkt_end
);

   localparam logic [POS_W-1:0] LAST_POS = POS_W'(PKT_LEN - 1);
   localparam int TMR_W = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC) : 1;

   logic [POS_W-1:0] pos_q;
   logic             expire;
   logic             at_id;

   assign at_id   = (pos_q == '0);
   assign id_drop = rx_valid && at_id && !id_ok;
   assign pkt_end = rx_valid && (pos_q == LAST_POS);
   assign pos     = pos_q;

   generate
      if (TIMEOUT_CYC > 0) begin : g_idle_tmr
         localparam logic [TMR_W-1:0] TMR_LIM = TMR_W'(TIMEOUT_CYC - 1);
         logic [TMR_W-1:0] idle_q;

         assign expire = !rx_valid && !at_id && (idle_q == TMR_LIM);

         always_ff @(posedge clk) begin
            if (!rst_n)
               idle_q <= '0;
            else if (rx_valid || at_id || expire)
               idle_q <= '0;
            else
               idle_q <= idle_q + 1'b1;
         end
      end else begin : g_no_tmr
         assign expire = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         pos_q <= '0;
      else if (expire)
         pos_q <= '0;
      else if (rx_valid) begin
         if (id_drop || pkt_end)
            pos_q <= '0;
         else
            pos_q <= pos_q + 1'b1;
      end
   end

endmodule

// File: rtl/cmd_pkt_capture.sv
module cmd_pkt_capture
   import cmd_pkt_pkg::*;
#(
   parameter int POS_W = 3
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_valid,
   input  byte_t            rx_byte,
   input  logic [POS_W-1:0] pos,
   output pkt_hdr_t         hdr
);

   byte_t fld_q [HDR_FLDS];

   generate
      for (genvar gi = 0; gi < HDR_FLDS; gi++) begin : g_fld
         always_ff @(posedge clk) begin
            if (!rst_n)
               fld_q[gi] <= '0;
            else if (rx_valid && pos == POS_W'(gi))
               fld_q[gi] <= rx_byte;
         end
      end
   endgenerate

   assign hdr.id  = fld_q[0];
   assign hdr.op1 = fld_q[1];
   assign hdr.op2 = fld_q[2];
   assign hdr.chk = fld_q[3];

endmodule

// File: rtl/cmd_pkt_check.sv
module cmd_pkt_check
   import cmd_pkt_pkg::*;
(
   input  pkt_hdr_t hdr,
   input  byte_t    trailer,
   output logic     pkt_ok
);

   logic tail_ok;
   logic integ_ok;
   logic inv_ok;
   logic is_bulk;

   always_comb begin
      is_bulk  = (hdr.id == ID_BULK_ADR);
      tail_ok  = (trailer == hdr.id);
      integ_ok = is_bulk ? (hdr.chk == '0)
                         : (hdr.chk == op_sum(hdr.op1, hdr.op2));
      inv_ok   = (hdr.id != ID_WR_BYTE) || (hdr.op2 == ~hdr.op1);
      pkt_ok   = tail_ok && integ_ok && inv_ok && id_is_legal(hdr.id);
   end

endmodule

// File: rtl/cmd_pkt_parser.sv
module cmd_pkt_parser
   import cmd_pkt_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int TIMEOUT_CYC = 1000
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_byte,
   output logic              cmd_valid,
   output logic [DATA_W-1:0] cmd_id,
   output logic [DATA_W-1:0] cmd_op1,
   output logic [DATA_W-1:0] cmd_op2,
   output logic              nak_req
);

   localparam int POS_W = $clog2(PKT_LEN);

   generate
      if (DATA_W != BYTE_W) begin : g_bad_width
         $error("cmd_pkt_parser: DATA_W must equal the protocol byte width");
      end
      if (TIMEOUT_CYC < 0) begin : g_bad_tmo
         $error("cmd_pkt_parser: TIMEOUT_CYC must not be negative");
      end
   endgenerate

   logic [POS_W-1:0] frm_pos;
   logic             id_drop;
   logic             pkt_end;
   logic             pkt_ok;
   pkt_hdr_t         hdr;

   cmd_pkt_framer #(
      .TIMEOUT_CYC (TIMEOUT_CYC),
      .POS_W       (POS_W)
   ) u_framer (
      .clk      (clk),
      .rst_n    (rst_n),
      .rx_valid (rx_valid),
      .id_ok    (id_is_legal(rx_byte)),
      .pos      (frm_pos),
      .id_drop  (id_drop),
      .pkt_end  (pkt_end)
   );

   cmd_pkt_capture #(
      .POS_W (POS_W)
   ) u_capture (
      .clk      (clk),
      .rst_n    (rst_n),
      .rx_valid (rx_valid),
      .rx_byte  (rx_byte),
      .pos      (frm_pos),
      .hdr      (hdr)
   );

   cmd_pkt_check u_check (
      .hdr     (hdr),
      .trailer (rx_byte),
      .pkt_ok  (pkt_ok)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_valid <= 1'b0;
         nak_req   <= 1'b0;
         cmd_id    <= '0;
         cmd_op1   <= '0;
         cmd_op2   <= '0;
      end else begin
         cmd_valid <= pkt_end && pkt_ok;
         nak_req   <= id_drop || (pkt_end && !pkt_ok);
         if (pkt_end && pkt_ok) begin
            cmd_id  <= hdr.id;
            cmd_op1 <= hdr.op1;
            cmd_op2 <= hdr.op2;
         end
      end
   end

endmodule

// File: rtl/cmd_pkt_parser_sva.sv
module cmd_pkt_parser_sva
   import cmd_pkt_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int TIMEOUT_CYC = 1000,
   parameter int POS_W       = 3
)(
   input logic              clk,
   input logic              rst_n,
   input logic              rx_valid,
   input logic [DATA_W-1:0] rx_byte,
   input logic              cmd_valid,
   input logic [DATA_W-1:0] cmd_id,
   input logic [DATA_W-1:0] cmd_op1,
   input logic [DATA_W-1:0] cmd_op2,
   input logic              nak_req,
   input logic [POS_W-1:0]  frm_pos
);

   p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_valid && nak_req));

   p_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> !cmd_valid);

   p_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> id_is_legal(cmd_id));

   p_trailer_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> (rst_n && $past(rx_valid) && $past(rx_byte) == cmd_id));

   p_inverse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_id == ID_WR_BYTE) |-> (cmd_op2 == ~cmd_op1));

   p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid || nak_req) |-> (frm_pos == '0));

   p_pos_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      frm_pos <= POS_W'(PKT_LEN - 1));

   generate
      if (TIMEOUT_CYC > 0) begin : g_tmo_chk
         localparam int CW = $clog2(TIMEOUT_CYC + 1);
         logic [CW-1:0] gap_q;
         always_ff @(posedge clk) begin
            if (!rst_n || rx_valid)
               gap_q <= '0;
            else if (gap_q != CW'(TIMEOUT_CYC))
               gap_q <= gap_q + 1'b1;
         end
         p_timeout_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (gap_q == CW'(TIMEOUT_CYC)) |-> (frm_pos == '0));
      end
   endgenerate

endmodule

bind cmd_pkt_parser cmd_pkt_parser_sva #(
   .DATA_W      (DATA_W),
   .TIMEOUT_CYC (TIMEOUT_CYC),
   .POS_W       (POS_W)
) u_sva (
   .clk       (clk),
   .rst_n     (rst_n),
   .rx_valid  (rx_valid),
   .rx_byte   (rx_byte),
   .cmd_valid (cmd_valid),
   .cmd_id    (cmd_id),
   .cmd_op1   (cmd_op1),
   .cmd_op2   (cmd_op2),
   .nak_req   (nak_req),
   .frm_pos   (frm_pos)
);

// File: tb/tb_cmd_pkt_parser.sv
`timescale 1ns/1ps
module tb_cmd_pkt_parser;

   localparam int TMO = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_valid = 1'b0;
   logic [7:0] rx_byte = 8'h00;
   logic       cmd_valid, nak_req;
   logic [7:0] cmd_id, cmd_op1, cmd_op2;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   cmd_pkt_parser #(.DATA_W(8), .TIMEOUT_CYC(TMO)) dut (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
      .cmd_valid(cmd_valid), .cmd_id(cmd_id), .cmd_op1(cmd_op1),
      .cmd_op2(cmd_op2), .nak_req(nak_req)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic put(input logic [7:0] b);
      @(negedge clk);
      rx_valid = 1'b1;
      rx_byte  = b;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         rx_valid = 1'b0;
         rx_byte  = 8'hC3 ^ 8'(i);
      end
   endtask

   task automatic put5(input logic [7:0] b0, b1, b2, b3, b4);
      put(b0); put(b1); put(b2); put(b3); put(b4);
   endtask

   // one idle edge, then look at the registered outputs
   task automatic expect_out(input string tag, input logic v, input logic n,
                             input logic [7:0] id, input logic [7:0] o1, input logic [7:0] o2);
      idle(1);
      chk({tag, " valid"}, cmd_valid, v);
      chk({tag, " nak"}, nak_req, n);
      if (v) chk({tag, " fields"}, {cmd_id, cmd_op1, cmd_op2}, {id, o1, o2});
      idle(1);
      chk({tag, " pulse ends"}, {cmd_valid, nak_req}, 2'b00);
   endtask

   task automatic t_reset;
      chk("R1 reset valid", cmd_valid, 1'b0);
      chk("R1 reset nak", nak_req, 1'b0);
      put5(8'h02, 8'h12, 8'h34, 8'h46, 8'h02);
      expect_out("R1 R3 R4 first packet read", 1, 0, 8'h02, 8'h12, 8'h34);
   endtask

   task automatic t_good_kinds;
      put5(8'h10, 8'h5A, 8'hA5, 8'hFF, 8'h10);
      expect_out("R6 byte write ok", 1, 0, 8'h10, 8'h5A, 8'hA5);
      put5(8'h11, 8'h01, 8'h02, 8'h03, 8'h11);
      expect_out("R3 word write", 1, 0, 8'h11, 8'h01, 8'h02);
      put5(8'h23, 8'hF0, 8'h20, 8'h10, 8'h23);
      expect_out("R4 sum wraps", 1, 0, 8'h23, 8'hF0, 8'h20);
      put5(8'h80, 8'h12, 8'h34, 8'h00, 8'h80);
      expect_out("R7 bulk zero byte", 1, 0, 8'h80, 8'h12, 8'h34);
   endtask

   task automatic t_bad_pkts;
      put5(8'h23, 8'h10, 8'h20, 8'h31, 8'h23);
      expect_out("R4 bad sum", 0, 1, 0, 0, 0);
      put5(8'h02, 8'h12, 8'h34, 8'h46, 8'h03);
      expect_out("R5 bad trailer", 0, 1, 0, 0, 0);
      put5(8'h10, 8'h5A, 8'hA4, 8'hFE, 8'h10);
      expect_out("R6 bad inverse", 0, 1, 0, 0, 0);
      put5(8'h80, 8'h12, 8'h34, 8'h46, 8'h80);
      expect_out("R7 bulk with sum", 0, 1, 0, 0, 0);
   endtask

   task automatic t_illegal_id;
      put(8'h06);
      idle(1);
      chk("R2 illegal id nak", nak_req, 1'b1);
      chk("R2 illegal id no cmd", cmd_valid, 1'b0);
      idle(1);
      chk("R2 nak one cycle", nak_req, 1'b0);
      put(8'h81);
      put5(8'h05, 8'h00, 8'hFF, 8'hFF, 8'h05);
      expect_out("R2 resync after illegal", 1, 0, 8'h05, 8'h00, 8'hFF);
   endtask

   task automatic t_back_to_back;
      put5(8'h02, 8'h01, 8'h01, 8'h02, 8'h02);
      put(8'h21);
      chk("R10 first of pair", cmd_valid, 1'b1);
      put(8'h40); put(8'h41); put(8'h81); put(8'h21);
      expect_out("R10 second of pair", 1, 0, 8'h21, 8'h40, 8'h41);
      put5(8'h03, 8'h01, 8'h01, 8'h00, 8'h03);
      put(8'h04);
      chk("R10 nak then gapless", nak_req, 1'b1);
      put(8'h10); put(8'h20); put(8'h30); put(8'h04);
      expect_out("R10 after nak", 1, 0, 8'h04, 8'h10, 8'h20);
   endtask

   task automatic t_timeout;
      put(8'h02); put(8'h12);
      idle(TMO);
      put5(8'h03, 8'hAA, 8'h11, 8'hBB, 8'h03);
      expect_out("R9 stale partial dropped", 1, 0, 8'h03, 8'hAA, 8'h11);
      put(8'h04); put(8'h11);
      idle(TMO - 1);
      put(8'h22); put(8'h33); put(8'h04);
      expect_out("R9 gap below limit", 1, 0, 8'h04, 8'h11, 8'h22);
   endtask

   task automatic t_ignore_idle;
      put(8'h22); put(8'h05);
      idle(3);
      chk("R11 no output while idle", {cmd_valid, nak_req}, 2'b00);
      put(8'h06); put(8'h0B); put(8'h22);
      expect_out("R11 idle bytes ignored", 1, 0, 8'h22, 8'h05, 8'h06);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_good_kinds();
      t_bad_pkts();
      t_illegal_id();
      t_back_to_back();
      t_timeout();
      t_ignore_idle();
      idle(2);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule